// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is a small bus master that walks one all-digital PLL through a full reprogramming cycle without processor help. A single-cycle `start` pulse captures the input divider N, the feedback multiplier M, the output divider M2, a flag selecting the fractional (high-speed) PLL variant, and the base address of the PLL's register window. From those values the block derives the DCO frequency, a high-speed band code and a sigma-delta word. It then puts the PLL into bypass, loads the new dividers, re-enables the outputs, returns the PLL to active mode and waits for lock.

All register traffic goes over a request/acknowledge port with 32-bit address and data and at most one transfer in flight. The block decodes these register offsets relative to the base address: control 0x04, M/N load-enable 0x08, M2/N2 load-enable 0x0C, M2/N divider 0x10, M divider 0x14, fractional divider 0x18, status 0x24. The run ends with `done` or `err` held high until the next accepted start. Both polling loops are bounded by the `timeout_lim` input.

The states are IDLE, CHECK, RD_IDLE, WR_IDLE, POLL_BYP, RD_TINIT, WR_TINIT, RD_WORK, WR_M2N, WR_M, WR_FRAC, WR_BAND, WR_TDIV_H, WR_TDIV_L, WR_TEN_H, WR_TEN_L, RD_EN, WR_EN, RD_ACT, WR_ACT and POLL_LOCK, visited in that order.
- IDLE goes to CHECK on `start`.
- CHECK returns to IDLE with an error on an out-of-range band. Otherwise it goes on to RD_IDLE.
- Each read or write state advances on `bus_ack`.
- WR_M skips WR_FRAC and WR_BAND on the integer variant.
- WR_TEN_L goes to RD_EN on the fractional variant and to RD_ACT otherwise.
- The two POLL states re-read status until their condition holds. They return to IDLE with an error if a failing read arrives once the timeout count has reached `timeout_lim`.
- POLL_LOCK returns to IDLE with `done` once lock is seen.

Top module: `pll_reprog_seq`

## Requirements
- R1: The DCO frequency is (20 / (N+1)) * M, with integer division before the multiply. On the fractional variant, a DCO in [500, 1000) gives band code 0x801 and a DCO in [1000, 2000) gives band code 0x1001. The band code is ORed into the working control value and written to control (0x04).
- R2: On the fractional variant, the fractional divider (0x18) is written with floor((DCO + 225) / 250) in bits [31:24] and zero in bits [23:0]. On the integer variant, 0x18 is not written.
- R3: On the fractional variant, a DCO outside both bands ends the run with `err`, and no bus request is issued. The integer variant performs no range check.
- R4: The run opens with a read of control and a write of that value with bit 23 (idle) set. The block then polls status (0x24) until bits 0 and 8 both read 1.
- R5: Control is then read and written back with bit 0 cleared. The working copy is read again with bits 12, 11 and 10 cleared. The block writes (M2 << 16) | N to 0x10, then M to 0x14.
- R6: The block writes 1 and then 0 to the M2/N2 load-enable register (0x0C). Only after that does it write 1 and then 0 to the M/N load-enable register (0x08).
- R7: On the fractional variant, control bits 29, 20, 19 and 17 are set in one read-modify-write. The last control write clears bit 23 and sets bit 0. On the integer variant, the low-power bits read back from the PLL are left as they were.
- R8: After the last control write, status is polled until bits 10 and 9 are both 1, and then `done` rises. `done` and `err` are never high together, and both clear when a new run is accepted.
- R9: In either polling state, a failing status read seen once `timeout_lim` cycles have been spent in that state ends the run with `err` and returns the block to idle.
- R10: `start` is ignored while `busy` is high. No bus request is issued while idle.
- R11: Once raised, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reprogramming run (taken only when idle) |
| n_div | input | N_W | Input divider N |
| m_mul | input | M_W | Feedback multiplier M |
| m2_div | input | M2_W | Output divider M2 |
| frac_sel | input | 1 | 1 selects the fractional/high-speed variant |
| base_addr | input | 32 | Base address of the PLL register window |
| timeout_lim | input | TO_W | Poll timeout in cycles |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed with lock |
| err | output | 1 | Last run aborted (range or timeout) |

## Verification
The bench builds the block with its defaults: an 8-bit N, a 12-bit M, a 7-bit M2 and a 16-bit timeout counter. With a 12-bit M, both band edges (500, 1000, 2000) and the truncating reference division (N=2) are reachable from small divider values. The 16-bit timeout is run at a limit of 20 cycles, so that both abort paths finish in a few dozen cycles. The register model delays bypass and lock by several cycles, so each polling loop retries before it succeeds.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    // register offsets inside the PLL window
    localparam logic [31:0] OFS_CTL  = 32'h04;
    localparam logic [31:0] OFS_TEN  = 32'h08;
    localparam logic [31:0] OFS_TDIV = 32'h0C;
    localparam logic [31:0] OFS_M2N  = 32'h10;
    localparam logic [31:0] OFS_M    = 32'h14;
    localparam logic [31:0] OFS_FRAC = 32'h18;
    localparam logic [31:0] OFS_STAT = 32'h24;

    // control and status bit masks
    localparam logic [31:0] CTL_IDLE  = 32'h0080_0000;
    localparam logic [31:0] CTL_TINIT = 32'h0000_0001;
    localparam logic [31:0] CTL_LPM   = 32'h0000_1C00;
    localparam logic [31:0] CTL_OUTEN = 32'h201A_0000;
    localparam logic [31:0] ST_BYP    = 32'h0000_0101;
    localparam logic [31:0] ST_LOCK   = 32'h0000_0600;

    // band codes and frequency constants (MHz)
    localparam logic [31:0] BAND_LO  = 32'h0000_0801;
    localparam logic [31:0] BAND_HI  = 32'h0000_1001;
    localparam int REF_MHZ  = 20;
    localparam int HS2_MIN  = 500;
    localparam int HS1_MIN  = 1000;
    localparam int HS1_MAX  = 2000;
    localparam int SIG_BIAS = 225;
    localparam int SIG_DIV  = 250;
    localparam int M2_SHIFT = 16;

    typedef enum logic [4:0] {
        S_IDLE, S_CHECK, S_RD_IDLE, S_WR_IDLE, S_POLL_BYP,
        S_RD_TINIT, S_WR_TINIT, S_RD_WORK, S_WR_M2N, S_WR_M,
        S_WR_FRAC, S_WR_BAND, S_WR_TDIV_H, S_WR_TDIV_L, S_WR_TEN_H,
        S_WR_TEN_L, S_RD_EN, S_WR_EN, S_RD_ACT, S_WR_ACT, S_POLL_LOCK
    } seq_state_e;

endpackage

// File: rtl/dco_band_calc.sv
module dco_band_calc
    import pll_seq_pkg::*;
#(
    parameter int N_W = 8,
    parameter int M_W = 12
) (
    input  logic [N_W-1:0] n_div,
    input  logic [M_W-1:0] m_mul,
    output logic [31:0]    band_code,
    output logic [31:0]    sigma_word,
    output logic           in_range
);
    localparam int REF_W = $clog2(REF_MHZ + 1);
    localparam int DCO_W = M_W + REF_W;

    logic [N_W:0]     n_plus1;
    logic [N_W:0]     ref_full;
    logic [DCO_W-1:0] dco;
    logic [DCO_W:0]   sig_sum;
    logic [DCO_W:0]   sig_quo;

    always_comb begin
        n_plus1  = {1'b0, n_div} + {{N_W{1'b0}}, 1'b1};
        ref_full = (N_W+1)'(REF_MHZ) / n_plus1;
        dco      = DCO_W'(ref_full[REF_W-1:0]) * DCO_W'(m_mul);
        sig_sum  = {1'b0, dco} + (DCO_W+1)'(SIG_BIAS);
        sig_quo  = sig_sum / (DCO_W+1)'(SIG_DIV);
        sigma_word = {sig_quo[7:0], 24'h0};
        in_range  = 1'b1;
        if (dco >= DCO_W'(HS2_MIN) && dco < DCO_W'(HS1_MIN)) begin
            band_code = BAND_LO;
        end else if (dco >= DCO_W'(HS1_MIN) && dco < DCO_W'(HS1_MAX)) begin
            band_code = BAND_HI;
        end else begin
            band_code = 32'h0;
            in_range  = 1'b0;
        end
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [TO_W-1:0] lim,
    output logic            expired
);
    localparam logic [TO_W-1:0] CNT_MAX = '1;

    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= lim);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int N_W  = 8,
    parameter int M_W  = 12,
    parameter int M2_W = 7,
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N_W-1:0]  n_div,
    input  logic [M_W-1:0]  m_mul,
    input  logic [M2_W-1:0] m2_div,
    input  logic            frac_sel,
    input  logic [31:0]     base_addr,
    input  logic [TO_W-1:0] timeout_lim,
    output logic            bus_req,
    output logic            bus_we,
    output logic [31:0]     bus_addr,
    output logic [31:0]     bus_wdata,
    input  logic            bus_ack,
    input  logic [31:0]     bus_rdata,
    output logic            busy,
    output logic            done,
    output logic            err
);
    seq_state_e state, nxt;

    logic [N_W-1:0]  n_q;
    logic [M_W-1:0]  m_q;
    logic [M2_W-1:0] m2_q;
    logic            frac_q;
    logic [31:0]     base_q;
    logic [31:0]     ctl_q;
    logic [31:0]     band_code, sigma_word, ofs;
    logic            in_range, expired, byp_ok, lock_ok, polling;

    dco_band_calc #(.N_W(N_W), .M_W(M_W)) calc_i (
        .n_div(n_q), .m_mul(m_q),
        .band_code(band_code), .sigma_word(sigma_word), .in_range(in_range)
    );

    assign polling = (state == S_POLL_BYP) || (state == S_POLL_LOCK);

    poll_timer #(.TO_W(TO_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(polling), .lim(timeout_lim), .expired(expired)
    );

    assign byp_ok  = (bus_rdata & ST_BYP) == ST_BYP;
    assign lock_ok = (bus_rdata & ST_LOCK) == ST_LOCK;
    assign busy    = (state != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start) nxt = S_CHECK;
            S_CHECK:     nxt = (frac_q && !in_range) ? S_IDLE : S_RD_IDLE;
            S_RD_IDLE:   if (bus_ack) nxt = S_WR_IDLE;
            S_WR_IDLE:   if (bus_ack) nxt = S_POLL_BYP;
            S_POLL_BYP:  if (bus_ack) begin
                             if (byp_ok)       nxt = S_RD_TINIT;
                             else if (expired) nxt = S_IDLE;
                         end
            S_RD_TINIT:  if (bus_ack) nxt = S_WR_TINIT;
            S_WR_TINIT:  if (bus_ack) nxt = S_RD_WORK;
            S_RD_WORK:   if (bus_ack) nxt = S_WR_M2N;
            S_WR_M2N:    if (bus_ack) nxt = S_WR_M;
            S_WR_M:      if (bus_ack) nxt = frac_q ? S_WR_FRAC : S_WR_TDIV_H;
            S_WR_FRAC:   if (bus_ack) nxt = S_WR_BAND;
            S_WR_BAND:   if (bus_ack) nxt = S_WR_TDIV_H;
            S_WR_TDIV_H: if (bus_ack) nxt = S_WR_TDIV_L;
            S_WR_TDIV_L: if (bus_ack) nxt = S_WR_TEN_H;
            S_WR_TEN_H:  if (bus_ack) nxt = S_WR_TEN_L;
            S_WR_TEN_L:  if (bus_ack) nxt = frac_q ? S_RD_EN : S_RD_ACT;
            S_RD_EN:     if (bus_ack) nxt = S_WR_EN;
            S_WR_EN:     if (bus_ack) nxt = S_RD_ACT;
            S_RD_ACT:    if (bus_ack) nxt = S_WR_ACT;
            S_WR_ACT:    if (bus_ack) nxt = S_POLL_LOCK;
            S_POLL_LOCK: if (bus_ack && (lock_ok || expired)) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // captured operands, working control copy and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0; m_q <= '0; m2_q <= '0; frac_q <= 1'b0; base_q <= '0;
            ctl_q <= '0; done <= 1'b0; err <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    n_q <= n_div; m_q <= m_mul; m2_q <= m2_div;
                    frac_q <= frac_sel; base_q <= base_addr;
                    done <= 1'b0; err <= 1'b0;
                end
                S_CHECK:     if (frac_q && !in_range) err <= 1'b1;
                S_RD_IDLE:   if (bus_ack) ctl_q <= bus_rdata | CTL_IDLE;
                S_POLL_BYP:  if (bus_ack && !byp_ok && expired) err <= 1'b1;
                S_RD_TINIT:  if (bus_ack) ctl_q <= bus_rdata & ~CTL_TINIT;
                S_RD_WORK:   if (bus_ack) ctl_q <= bus_rdata & ~CTL_LPM;
                S_RD_EN:     if (bus_ack) ctl_q <= (bus_rdata & ~CTL_OUTEN) | CTL_OUTEN;
                S_RD_ACT:    if (bus_ack) ctl_q <= (bus_rdata & ~CTL_IDLE) | CTL_TINIT;
                S_POLL_LOCK: if (bus_ack) begin
                    if (lock_ok)      done <= 1'b1;
                    else if (expired) err  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // bus outputs
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        ofs       = OFS_CTL;
        bus_wdata = 32'h0;
        unique case (state)
            S_IDLE, S_CHECK: bus_req = 1'b0;
            S_RD_IDLE, S_RD_TINIT, S_RD_WORK, S_RD_EN, S_RD_ACT: ;
            S_POLL_BYP, S_POLL_LOCK: ofs = OFS_STAT;
            S_WR_IDLE, S_WR_TINIT, S_WR_EN, S_WR_ACT: begin
                bus_we = 1'b1; bus_wdata = ctl_q;
            end
            S_WR_BAND: begin bus_we = 1'b1; bus_wdata = ctl_q | band_code; end
            S_WR_M2N: begin
                bus_we = 1'b1; ofs = OFS_M2N;
                bus_wdata = (32'(m2_q) << M2_SHIFT) | 32'(n_q);
            end
            S_WR_M:      begin bus_we = 1'b1; ofs = OFS_M;    bus_wdata = 32'(m_q); end
            S_WR_FRAC:   begin bus_we = 1'b1; ofs = OFS_FRAC; bus_wdata = sigma_word; end
            S_WR_TDIV_H: begin bus_we = 1'b1; ofs = OFS_TDIV; bus_wdata = 32'h1; end
            S_WR_TDIV_L: begin bus_we = 1'b1; ofs = OFS_TDIV; end
            S_WR_TEN_H:  begin bus_we = 1'b1; ofs = OFS_TEN;  bus_wdata = 32'h1; end
            S_WR_TEN_L:  begin bus_we = 1'b1; ofs = OFS_TEN;  end
            default: bus_req = 1'b0;
        endcase
    end

    assign bus_addr = base_q + ofs;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic [31:0] bus_rdata,
    input logic        busy,
    input logic        done,
    input logic        err
);
    // R11: a pending request holds until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R8: done and err are exclusive
    a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R8: done rises only after a status read showing both lock bits
    a_r8_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_ack && !bus_we && bus_rdata[10] && bus_rdata[9]));

    // R10: result flags are cleared while a run is in progress
    a_r10_busy_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done && !err);

    // R10: an idle block issues no bus request
    a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R9: an error is raised only at the end of a run
    a_r9_err_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err)
);

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
    localparam int N_W = 8, M_W = 12, M2_W = 7, TO_W = 16;
    localparam logic [31:0] BASE     = 32'h0000_1000;
    localparam logic [31:0] CTL_INIT = 32'h0000_1C20;
    localparam logic [31:0] OUTEN    = 32'h201A_0000;
    localparam int NV = 11;
    // vector table: N, M, M2, fractional, expected band, expected sigma, expected error
    localparam int VN   [NV] = '{19, 19, 1, 0, 1, 0, 0, 0, 2, 0, 1};
    localparam int VM   [NV] = '{880, 666, 60, 60, 50, 50, 100, 20, 100, 20, 99};
    localparam int VM2  [NV] = '{4, 2, 1, 1, 3, 5, 1, 1, 2, 9, 6};
    localparam int VF   [NV] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 0, 1};
    localparam int VBAND[NV] = '{'h801, 'h801, 0, 'h1001, 'h801, 'h1001, 0, 0, 'h801, 0, 'h801};
    localparam int VSIG [NV] = '{4, 3, 0, 5, 2, 4, 0, 0, 3, 0, 4};
    localparam int VERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0, start = 1'b0, frac_sel = 1'b0;
    logic [N_W-1:0]  n_div = '0;
    logic [M_W-1:0]  m_mul = '0;
    logic [M2_W-1:0] m2_div = '0;
    logic [31:0]     base_addr = BASE;
    logic [TO_W-1:0] timeout_lim = 16'd1000;
    logic            bus_req, bus_we, bus_ack, busy, done, err;
    logic [31:0]     bus_addr, bus_wdata, bus_rdata;

    pll_reprog_seq #(.N_W(N_W), .M_W(M_W), .M2_W(M2_W), .TO_W(TO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .m_mul(m_mul),
        .m2_div(m2_div), .frac_sel(frac_sel), .base_addr(base_addr),
        .timeout_lim(timeout_lim), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err)
    );

    // PLL register model
    logic [31:0] regs [12];
    logic        mclr = 1'b1, no_byp = 1'b0, no_lock = 1'b0;
    int          byp_cnt, lock_cnt, wr_cnt, tdiv_last, ten_first, ten_cnt, idx;
    logic [3:0]  tdiv_hist, ten_hist;
    logic        st_byp, st_lock;

    assign st_byp  = (byp_cnt >= 4) && !no_byp;
    assign st_lock = (lock_cnt >= 6) && !no_lock;

    always @(posedge clk) begin
        if (mclr) begin
            for (int i = 0; i < 12; i++) regs[i] <= (i == 1) ? CTL_INIT : 32'h0;
            byp_cnt <= 0; lock_cnt <= 0; wr_cnt <= 0; tdiv_last <= 0;
            ten_first <= 0; ten_cnt <= 0; tdiv_hist <= 0; ten_hist <= 0;
            bus_ack <= 1'b0; bus_rdata <= 32'h0;
        end else begin
            byp_cnt  <= regs[1][23] ? byp_cnt + 1 : 0;
            lock_cnt <= (!regs[1][23] && regs[1][0]) ? lock_cnt + 1 : 0;
            bus_ack  <= 1'b0;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                idx = int'((bus_addr - BASE) >> 2);
                if (bus_we) begin
                    if (idx < 12) regs[idx] <= bus_wdata;
                    wr_cnt <= wr_cnt + 1;
                    if (idx == 3) begin
                        tdiv_hist <= {tdiv_hist[2:0], bus_wdata[0]};
                        tdiv_last <= wr_cnt;
                    end
                    if (idx == 2) begin
                        ten_hist <= {ten_hist[2:0], bus_wdata[0]};
                        if (ten_cnt == 0) ten_first <= wr_cnt;
                        ten_cnt <= ten_cnt + 1;
                    end
                end else if (idx == 9) begin
                    bus_rdata <= {21'h0, st_lock, st_lock, st_byp, 7'h0, st_byp};
                end else if (idx < 12) begin
                    bus_rdata <= regs[idx];
                end
            end
        end
    end

    // independent monitor of request holding (R11)
    int hold_viol = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = 32'h0;
    always @(negedge clk) begin
        if (rst_n && prev_pend && (!bus_req || bus_addr != prev_addr)) hold_viol++;
        prev_pend = bus_req && !bus_ack;
        prev_addr = bus_addr;
    end

    int checks = 0, fails = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(int n, int m, int m2, int f, int lim, bit nb, bit nl);
        @(negedge clk);
        mclr = 1'b1; no_byp = nb; no_lock = nl;
        @(negedge clk);
        mclr = 1'b0;
        n_div = N_W'(n); m_mul = M_W'(m); m2_div = M2_W'(m2);
        frac_sel = f[0]; timeout_lim = TO_W'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int c = 0; c < 5000 && !(done || err); c++) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_ctl(int f, int band);
        if (f != 0) return (CTL_INIT & ~32'h1C00) | 32'(band) | OUTEN | 32'h1;
        return CTL_INIT | 32'h1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R8, R10)
        check("R10 busy after reset", 32'(busy), 32'h0);
        check("R10 req after reset", 32'(bus_req), 32'h0);
        check("R8 done/err after reset", {30'h0, done, err}, 32'h0);
        rst_n = 1'b1;

        // vector table (R1, R2, R3, R5, R6, R7, R8)
        for (int v = 0; v < NV; v++) begin
            launch(VN[v], VM[v], VM2[v], VF[v], 1000, 1'b0, 1'b0);
            wait_end();
            if (VERR[v] != 0) begin
                check("R3 err on out-of-range band", 32'(err), 32'h1);
                check("R3 done low on abort", 32'(done), 32'h0);
                check("R3 no bus writes on abort", 32'(wr_cnt), 32'h0);
            end else begin
                check("R8 done after lock", {30'h0, done, err}, 32'h2);
                check("R5 M2/N register", regs[4], (32'(VM2[v]) << 16) | 32'(VN[v]));
                check("R5 M register", regs[5], 32'(VM[v]));
                check("R1 R7 final control", regs[1], exp_ctl(VF[v], VBAND[v]));
                check("R2 fractional divider", regs[6], (VF[v] != 0) ? (32'(VSIG[v]) << 24) : 32'h0);
                check("R6 M2/N2 strobe 1 then 0", 32'(tdiv_hist), 32'h2);
                check("R6 M/N strobe 1 then 0", 32'(ten_hist), 32'h2);
                check("R6 strobe order", 32'(tdiv_last < ten_first), 32'h1);
                check("R10 idle after run", 32'(busy), 32'h0);
            end
        end

        // bypass never acknowledged (R4, R9)
        launch(19, 880, 4, 1, 20, 1'b1, 1'b0);
        wait_end();
        check("R9 err on bypass timeout", {30'h0, done, err}, 32'h1);
        check("R4 single idle write before poll", 32'(wr_cnt), 32'h1);
        check("R4 idle bit set by read-modify-write", regs[1], CTL_INIT | 32'h0080_0000);
        check("R9 back to idle", 32'(busy), 32'h0);

        // lock never reached (R9)
        launch(19, 880, 4, 1, 20, 1'b0, 1'b1);
        wait_end();
        check("R9 err on lock timeout", {30'h0, done, err}, 32'h1);
        check("R9 all writes issued before lock poll", 32'(wr_cnt), 32'd12);

        // start while busy is ignored (R10)
        launch(19, 880, 4, 1, 1000, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        n_div = 8'd0; m_mul = 12'd60; m2_div = 7'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        check("R10 first run completes", 32'(done), 32'h1);
        check("R10 second start ignored (M2/N)", regs[4], (32'd4 << 16) | 32'd19);
        check("R10 second start ignored (write count)", 32'(wr_cnt), 32'd12);

        // request holding across all runs (R11)
        check("R11 request held until ack", 32'(hold_viol), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule